// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

The block multiplies two 32-bit two's-complement numbers and returns the 64-bit signed product as an upper word and a lower word. It is iterative. One adder/subtractor is reused over sixteen steps, and each step retires two multiplier bits through modified Booth recoding. The recoder looks at the two lowest bits of the low product register and a saved bit from the previous step. It then adds zero, one times or two times the multiplicand to the upper partial product, or subtracts one of those multiples. After the add or subtract, the upper and lower registers shift right together by two places.

A client pulses `start_i` while the block is idle. The operands are presented in that same cycle. `busy_o` stays high while the block iterates. `done_o` pulses for one cycle when the result words are valid. The result words then hold their value until the next accepted start.

Top module: `booth_mul`

## Requirements
- R1: When reset is asserted (`rst_ni` low), `busy_o` and `done_o` are 0 and `hi_o`/`lo_o` are 0.
- R2: A start seen at a rising edge while `busy_o` is low is accepted. `busy_o` is high for the next 16 cycles and then drops.
- R3: `done_o` is high for exactly one cycle, the cycle after the 16th step. This is the 16th rising edge after the accepting edge. `done_o` and `busy_o` are never high together.
- R4: When `done_o` is high, `{hi_o, lo_o}` equals the signed 64-bit product of the accepted multiplicand and multiplier.
- R5: The most negative operand squared, 0x80000000 times 0x80000000, gives `hi_o`=0x40000000 and `lo_o`=0x00000000. Operands at the most positive value and at -1 also give exact products.
- R6: A start raised while `busy_o` is high is ignored. The running product, its operands and its completion cycle are unchanged.
- R7: Each step recodes {LO[1], LO[0], prev} as follows:
  - 000 and 111 mean +0.
  - 001 and 010 mean +1x.
  - 011 means +2x.
  - 100 means -2x.
  - 101 and 110 mean -1x.

  prev is 0 at start. Alternating bit patterns and runs of ones, which use every code, give exact products.
- R8: After `done_o`, `hi_o`/`lo_o` hold the product until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply; operands sampled with it |
| mcand_i | input | 32 | Multiplicand, two's complement |
| mplier_i | input | 32 | Multiplier, two's complement |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle pulse: product valid |
| hi_o | output | 32 | Upper product word |
| lo_o | output | 32 | Lower product word |

## Verification
An accepted start raises `busy_o` one edge later. `done_o` and the final product appear 16 edges after the accepting edge, and the product is then held. The bench keeps a behavioural model that counts those edges from the sampled start. On every falling edge the model is compared with `busy_o` and `done_o`. The product words are compared whenever the model says the block is idle, so a result that arrives one cycle early or late is reported. Operands are driven only on falling edges, and both the model and the design see them settled at the next rising edge.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // recoded step: nz = use a multiple, dbl = 2x, neg = subtract
  typedef struct packed {
    logic neg;
    logic dbl;
    logic nz;
  } booth_sel_t;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [1:0] grp_i,
  input  logic       prev_i,
  output booth_sel_t sel_o
);
  always_comb begin
    unique case ({grp_i, prev_i})
      3'b001, 3'b010: sel_o = '{neg: 1'b0, dbl: 1'b0, nz: 1'b1};
      3'b011:         sel_o = '{neg: 1'b0, dbl: 1'b1, nz: 1'b1};
      3'b100:         sel_o = '{neg: 1'b1, dbl: 1'b1, nz: 1'b1};
      3'b101, 3'b110: sel_o = '{neg: 1'b1, dbl: 1'b0, nz: 1'b1};
      default:        sel_o = '{neg: 1'b0, dbl: 1'b0, nz: 1'b0};
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int unsigned OP_W  = 32,
  localparam int unsigned ACC_W = OP_W + 2
) (
  input  logic [OP_W-1:0]  hi_i,
  input  logic [OP_W-1:0]  mcand_i,
  input  booth_sel_t       sel_i,
  output logic [ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0] hi_ext, mc_ext, mult, operand;

  assign hi_ext  = {{2{hi_i[OP_W-1]}}, hi_i};
  assign mc_ext  = {{2{mcand_i[OP_W-1]}}, mcand_i};
  assign mult    = sel_i.dbl ? {mc_ext[ACC_W-2:0], 1'b0} : mc_ext;
  assign operand = sel_i.nz ? mult : '0;
  assign sum_o   = sel_i.neg ? (hi_ext - operand) : (hi_ext + operand);
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int unsigned STEPS = 16,
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign accept_o = start_i && !busy_q;
  assign step_o   = busy_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start_i) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end
    end
  end

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r3_done_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && busy_q));
  a_r3_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $fell(busy_q));
  a_r6_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != LAST) |=> busy_q);
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int unsigned OP_W = 32,
  localparam int unsigned ACC_W = OP_W + 2,
  localparam int unsigned STEPS = OP_W / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] mcand_i,
  input  logic [OP_W-1:0] mplier_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [OP_W-1:0] hi_o,
  output logic [OP_W-1:0] lo_o
);
  logic             accept, step;
  logic [OP_W-1:0]  mcand_q, hi_q, lo_q;
  logic             prev_q;
  booth_sel_t       sel;
  logic [ACC_W-1:0] sum;

  booth_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  booth_recoder u_rec (
    .grp_i (lo_q[1:0]),
    .prev_i(prev_q),
    .sel_o (sel)
  );

  booth_addsub #(.OP_W(OP_W)) u_addsub (
    .hi_i   (hi_q),
    .mcand_i(mcand_q),
    .sel_i  (sel),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      prev_q  <= 1'b0;
    end else if (accept) begin
      mcand_q <= mcand_i;
      hi_q    <= '0;
      lo_q    <= mplier_i;
      prev_q  <= 1'b0;
    end else if (step) begin
      // arithmetic shift by two: bits leaving HI enter the top of LO
      hi_q   <= sum[ACC_W-1:2];
      lo_q   <= {sum[1:0], lo_q[OP_W-1:2]};
      prev_q <= lo_q[1];
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  a_r6_mcand_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mcand_q));
  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(hi_q) && $stable(lo_q)));
  a_r7_zero_passes_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !sel.nz) |=> (hi_q == $past(hi_q) >>> 2 || 1'b1) && ($signed(hi_q) == ($signed($past(hi_q)) >>> 2)));
  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (busy_o && prev_q == 1'b0));
endmodule

// File: tb/booth_mul_bench.sv
`timescale 1ns/1ps
module booth_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] mcand = '0, mplier = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int n_cmp = 0, n_bad = 0, cycle = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural model state
  bit          m_busy = 0, m_done = 0;
  int          m_cnt = 0;
  logic [63:0] m_pend = '0, m_res = '0;

  always #2.5 clk = ~clk;

  booth_mul u_booth_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  always @(posedge clk) begin
    cycle++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 16) begin
          m_busy = 0; m_done = 1; m_res = m_pend;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        m_pend = 64'($signed(mcand) * $signed(mplier));
      end
    end
    if (cycle > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (busy !== m_busy) begin
      n_bad++;
      $display("FAIL R2 busy: actual=%b expected=%b", busy, m_busy);
    end
    n_cmp++;
    if (done !== m_done) begin
      n_bad++;
      $display("FAIL R3 done: actual=%b expected=%b", done, m_done);
    end
    if (!m_busy) begin
      n_cmp++;
      if ({hi, lo} !== m_res) begin
        n_bad++;
        $display("FAIL %s product: actual=%h_%h expected=%h", tag, hi, lo, m_res);
      end
    end
  end

  task automatic run_mul(input logic [31:0] a, input logic [31:0] b, input string t);
    @(negedge clk);
    tag = t; mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    rst_n = 1'b1;
    @(negedge clk);
    run_mul(32'd3, 32'd5, "R4");
    run_mul(-32'sd7, 32'd9, "R4");
    run_mul(32'd123456, -32'sd98765, "R4");
    run_mul(32'h0, 32'hdeadbeef, "R4");
    run_mul(32'h80000000, 32'h80000000, "R5");
    run_mul(32'h7fffffff, 32'h7fffffff, "R5");
    run_mul(32'h80000000, 32'h7fffffff, "R5");
    run_mul(32'hffffffff, 32'hffffffff, "R5");
    run_mul(32'h80000000, 32'h00000001, "R5");
    run_mul(32'h12345678, 32'h55555555, "R7");
    run_mul(32'h9abcdef0, 32'haaaaaaaa, "R7");
    run_mul(32'h0f0f0f0f, 32'hcccccccc, "R7");
    run_mul(32'hfedcba98, 32'h33333333, "R7");
    run_mul(32'h00000011, 32'h7ffffffe, "R7");
    for (int i = 0; i < 40; i++) run_mul($urandom, $urandom, "R4");
    // R6: extra start pulses while busy must not disturb the first product
    @(negedge clk);
    tag = "R6"; mcand = 32'h00001234; mplier = 32'hffff0001; start = 1'b1;
    @(negedge clk);
    mcand = 32'h7777_7777; mplier = 32'h5555_5555;
    repeat (4) @(negedge clk);
    start = 1'b0; mcand = 32'h1; mplier = 32'h1;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    // R8: result held while idle with inputs toggling
    tag = "R8";
    for (int i = 0; i < 10; i++) begin
      mcand = $urandom; mplier = $urandom;
      @(negedge clk);
    end
    // R1: reset mid-run clears state
    start = 1'b1; mcand = 32'h55; mplier = 32'h66;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    tag = "R1";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_mul(32'hffff8000, 32'h00008000, "R4");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule